// File: doc/BRIEF.md
# Segment LCD display mode selector

This block sits between the register interface and the waveform generator of a segment LCD controller. It keeps two copies of the segment pattern for every common line. Software writes the user buffer. The display buffer is what the panel shows. At each end-of-frame pulse from the timing generator, the user buffer is copied into the display buffer. Software can hold the display buffer frozen while it rewrites the user buffer, so a half-updated picture never reaches the glass.

A 3-bit display mode picks how the stored pattern becomes the segment vector for the selected common line. The choices are:
- show the pattern unchanged;
- force all segments off;
- force all segments on;
- invert the pattern;
- blank the pattern or its inverse on alternate blink phases;
- switch between the user and display buffers on alternate blink phases.

A requested mode is adopted only at a frame boundary. The blink phase is a level from the timing generator. The segment output is combinational from the held state, the common-line index and the blink phase.

Top module: `seg_lcd_mode_sel`

## Requirements
- R1: After reset, both buffers hold zero, the mode in effect is 0, and `seg` is all zeros.
- R2: A write with `wr_en` stores into the user buffer only. The common line is `wr_addr[AW-1:1]`. `wr_addr[0]` = 0 selects the low word, segments 31..0, taken from `wr_data[31:0]`. `wr_addr[0]` = 1 selects the high word, segments NSEG-1..32, taken from `wr_data[NSEG-33:0]`; the higher data bits are ignored. A write alone never changes `seg` in modes 0 to 6.
- R3: On a cycle with `eof` high and `mode_req` not equal to 6, the display buffer takes the user-buffer contents as they were before any write in that same cycle. The display buffer never changes on a cycle without `eof`.
- R4: The mode in effect takes the value of `mode_req` only on an `eof` cycle. It is held on all other cycles.
- R5: In modes 0 and 6, `seg` equals the display-buffer entry of common line `com_sel`.
- R6: Mode 1 drives `seg` all zeros and mode 2 drives it all ones. Neither mode alters any buffer, so returning to mode 0 shows the earlier pattern.
- R7: In mode 3, `seg` shows the display-buffer pattern while `blink` is 0 and all zeros while `blink` is 1.
- R8: Mode 4 shows the bitwise inverse of the display-buffer pattern. Mode 5 shows that inverse while `blink` is 0 and all zeros while `blink` is 1.
- R9: An `eof` with `mode_req` equal to 6 leaves the display buffer unchanged.
- R10: In mode 7, `seg` shows the user-buffer entry of `com_sel` while `blink` is 0 and the display-buffer entry while `blink` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | User-buffer write strobe |
| wr_addr | input | AW | Word address: common index above, high/low word select in bit 0 |
| wr_data | input | 32 | Write data |
| mode_req | input | 3 | Requested display mode |
| blink | input | 1 | Blink phase level from the timing generator |
| eof | input | 1 | End-of-frame pulse |
| com_sel | input | CW | Active common line |
| seg | output | NSEG | Segment pattern for the active common line |

## Verification
The assertions assume that `eof` is the only event that moves the frame-level state. They also assume that `blink` is a plain level whose meaning the block does not need to qualify. The stimulus raises `eof` on roughly a quarter of the cycles, at random, so that many cycles have `mode_req` changing with no frame boundary. Address and data values are random, and `com_sel` and `blink` change freely, because the output is defined for any combination. The directed cases cover the frozen-copy sequence, a high-word write with extra data bits set, and a write on the same cycle as a copy.

// File: rtl/seg_lcd_mode_sel.sv
module seg_lcd_mode_sel #(
  parameter int NCOM = 4,
  parameter int NSEG = 40,
  localparam int CW  = (NCOM > 1) ? $clog2(NCOM) : 1,
  localparam int AW  = CW + 1,
  localparam int HIW = NSEG - 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [2:0]      mode_req,
  input  logic            blink,
  input  logic            eof,
  input  logic [CW-1:0]   com_sel,
  output logic [NSEG-1:0] seg
);

  localparam logic [2:0] M_NORM = 3'd0, M_OFF = 3'd1, M_ON = 3'd2, M_BLK = 3'd3,
                         M_INV = 3'd4, M_IBLK = 3'd5, M_HOLD = 3'd6, M_SWAP = 3'd7;

  logic [NCOM-1:0][NSEG-1:0] ubuf, dbuf;
  logic [2:0]                mode_q;
  logic [CW-1:0]             wcom;
  logic [NSEG-1:0]           dsel, usel;

  assign wcom = wr_addr[AW-1:1];
  assign dsel = (int'(com_sel) < NCOM) ? dbuf[com_sel] : '0;
  assign usel = (int'(com_sel) < NCOM) ? ubuf[com_sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ubuf   <= '0;
      dbuf   <= '0;
      mode_q <= M_NORM;
    end else begin
      if (wr_en && int'(wcom) < NCOM) begin
        if (wr_addr[0]) ubuf[wcom][NSEG-1:32] <= wr_data[HIW-1:0];
        else            ubuf[wcom][31:0]      <= wr_data;
      end
      if (eof) begin
        mode_q <= mode_req;
        if (mode_req != M_HOLD) dbuf <= ubuf;
      end
    end
  end

  always_comb begin
    case (mode_q)
      M_OFF:   seg = '0;
      M_ON:    seg = '1;
      M_BLK:   seg = blink ? '0 : dsel;
      M_INV:   seg = ~dsel;
      M_IBLK:  seg = blink ? '0 : ~dsel;
      M_SWAP:  seg = blink ? dsel : usel;
      default: seg = dsel;
    endcase
  end

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |=> $stable(mode_q));
  assert_dbuf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |=> $stable(dbuf));
  assert_copy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && mode_req == M_HOLD) |=> $stable(dbuf));
  assert_force_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |-> (seg == '0));
  assert_force_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ON) |-> (&seg));
  assert_blank_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_BLK || mode_q == M_IBLK) && blink) |-> (seg == '0));
  assert_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_INV) |-> ((seg ^ dbuf[com_sel]) == '1));

endmodule

// File: tb/test_seg_lcd_mode_sel.sv
module test_seg_lcd_mode_sel;
  localparam int NCOM = 4, NSEG = 40, CW = 2, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, blink = 1'b0, eof = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] mode_req = '0;
  logic [CW-1:0] com_sel = '0;
  logic [NSEG-1:0] seg;

  logic [NSEG-1:0] mu [NCOM];
  logic [NSEG-1:0] md [NCOM];
  logic [2:0] mmode;
  int n_chk = 0, n_bad = 0;
  string mtag [8] = '{"R5", "R6", "R6", "R7", "R8", "R8", "R9", "R10"};

  seg_lcd_mode_sel #(.NCOM(NCOM), .NSEG(NSEG)) i_seg_lcd_mode_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_req(mode_req), .blink(blink), .eof(eof), .com_sel(com_sel), .seg(seg));

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [NSEG-1:0] expv(input logic [CW-1:0] c, input logic bl);
    logic [NSEG-1:0] d = md[c], u = mu[c];
    case (mmode)
      3'd1: return '0;
      3'd2: return '1;
      3'd3: return bl ? '0 : d;
      3'd4: return ~d;
      3'd5: return bl ? '0 : ~d;
      3'd7: return bl ? d : u;
      default: return d;
    endcase
  endfunction

  task automatic check(input logic [NSEG-1:0] exp, input string tag);
    n_chk++;
    if (seg !== exp) begin
      n_bad++;
      $display("FAIL %s: seg actual %h expected %h (mode %0d)", tag, seg, exp, mmode);
    end
  endtask

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [2:0] m, input logic e, input logic bl,
                      input logic [CW-1:0] c, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; mode_req = m; eof = e; blink = bl; com_sel = c;
    @(posedge clk);
    if (e) begin
      mmode = m;
      if (m != 3'd6) for (int i = 0; i < NCOM; i++) md[i] = mu[i];
    end
    if (we) begin
      if (a[0]) mu[a[AW-1:1]][NSEG-1:32] = d[NSEG-33:0];
      else      mu[a[AW-1:1]][31:0] = d;
    end
    #1;
    check(expv(c, bl), (tag == "") ? mtag[mmode] : tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCOM; i++) begin mu[i] = '0; md[i] = '0; end
    mmode = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    check('0, "R1");
    @(negedge clk); rst_n = 1'b1;
    #1;
    check('0, "R1");

    step(1, 3'b000, 32'hA5A5_0F0F, 0, 0, 0, 0, "R2");
    step(1, 3'b001, 32'hFFFF_FF3C, 0, 0, 0, 0, "R2");
    check({8'h00, 32'h0}, "R2");
    step(0, 0, 0, 0, 1, 0, 0, "R3");
    check({8'h3C, 32'hA5A5_0F0F}, "R3");
    step(0, 0, 0, 3'd1, 0, 0, 0, "R4");
    step(0, 0, 0, 3'd1, 1, 0, 0, "R6");
    step(0, 0, 0, 3'd0, 1, 0, 0, "R6");
    check({8'h3C, 32'hA5A5_0F0F}, "R6");
    step(1, 3'b010, 32'h1234_5678, 3'd0, 1, 0, 1, "R3");
    check('0, "R3");
    step(0, 0, 0, 3'd0, 1, 0, 1, "R3");

    for (int k = 0; k < 4000; k++)
      step(($urandom % 2) == 0, AW'($urandom), $urandom, 3'($urandom),
           ($urandom % 4) == 0, 1'($urandom), CW'($urandom), "");

    step(0, 0, 0, 3'd0, 1, 0, 2, "R5");
    step(0, 0, 0, 3'd6, 1, 0, 2, "R9");
    step(1, 3'b100, 32'hCAFE_F00D, 3'd6, 0, 0, 2, "R9");
    step(0, 0, 0, 3'd6, 1, 0, 2, "R9");
    step(0, 0, 0, 3'd7, 1, 0, 2, "R10");
    step(1, 3'b100, 32'h0BAD_BEEF, 3'd7, 0, 0, 2, "R10");
    step(0, 0, 0, 3'd7, 0, 1, 2, "R10");
    step(0, 0, 0, 3'd3, 1, 0, 2, "R7");
    step(0, 0, 0, 3'd3, 0, 1, 2, "R7");
    step(0, 0, 0, 3'd5, 1, 0, 2, "R8");
    step(0, 0, 0, 3'd5, 0, 1, 2, "R8");
    step(0, 0, 0, 3'd4, 1, 1, 2, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule